// File: doc/BRIEF.md
# Shifted-Operand Integer ALU with Flags Register

This block performs 32-bit ADD, SUB, AND, OR and XOR on two operands, one of which first passes through a left barrel shift. The shift amount is a 5-bit input. A polarity input chooses whether the shift acts on operand A or on operand B. Each operation takes two cycles. The block registers the result and raises a one-cycle `done` strobe. A new operation can begin on every cycle.

The block holds the architectural condition flags: carry, signed overflow, negative and zero. ADD and SUB rewrite all four flags. The logic operations rewrite only negative and zero. A per-operation suppress input leaves the flags untouched. A separate store port copies the low four bits of a 32-bit value into the flags. The flags are always readable, zero-extended to 32 bits, so instructions that move the flags out have a source. Register reads, instruction decode and condition evaluation are done by the surrounding pipeline.

Top module: `shift_alu_flags`

## Requirements
- R1: When `shift_a` is 1, operand A is shifted left by `shamt` (zeros enter) and operand B is used unshifted.
- R2: When `shift_a` is 0, operand B is shifted left by `shamt` and operand A is used unshifted.
- R3: A `shamt` of 0 leaves both operands unchanged.
- R4: `op` 0 (ADD) gives A'+B' modulo 2^32. It sets carry to the carry out of bit 31, sets overflow when both inputs have the same sign and the sum has a different sign, and sets negative and zero from the result.
- R5: `op` 1 (SUB) gives A'-B' modulo 2^32. Carry is set when A' < B' as unsigned values (a borrow). Overflow is set when the input signs differ and the result sign differs from A'. Negative and zero come from the result.
- R6: `op` 2/3/4 (AND/OR/XOR) update only negative and zero. Carry and overflow keep their previous values.
- R7: When `keep_flags` is 1 with `start`, the flags do not change, but the result is still produced.
- R8: An operation started in cycle c raises `done` for exactly cycle c+2, with `result` valid in that cycle and the flag update visible on `flg_out` in that cycle. Starts in consecutive cycles complete in consecutive cycles.
- R9: `flg_store` copies `flg_src[3:0]` into the flags. The new value is visible on `flg_out` in the next cycle.
- R10: `flg_out` holds {carry, overflow, negative, zero} in bits 3..0, and bits 31..4 are zero.
- R11: If a flag store and an ALU flag update take effect on the same clock edge, the stored value wins.
- R12: `op` codes 5, 6 and 7 give a result of 0 and leave the flags unchanged, but still raise `done`.
- R13: After reset, `done` is 0, `result` is 0 and the flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation this cycle |
| op | input | 3 | Operation code (0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR) |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| shamt | input | 5 | Left shift amount |
| shift_a | input | 1 | 1: shift A, 0: shift B |
| keep_flags | input | 1 | Suppress the flag update of this operation |
| flg_store | input | 1 | Load flags from `flg_src[3:0]` |
| flg_src | input | 32 | Source value for a flag store |
| done | output | 1 | Result valid strobe |
| result | output | 32 | Operation result |
| flg_out | output | 32 | Flags, zero-extended |

## Verification
The two functions that can meet in one cycle are the ALU flag write of an operation in its second stage and a flag store. To provoke this, the bench asserts `flg_store` in the cycle just after the `start` of a flag-writing operation, so that both land on the same edge. The bench judges the outcome at the following `done`: `flg_out` must equal the stored nibble and not the arithmetic flags. A second case pairs a store with a suppressed operation, so that only the store can change the flags.

// File: rtl/salu_pkg.sv
// Package: shared operation codes and flag bit positions for the shifted ALU.
// Assumes flags are packed {carry, overflow, negative, zero} from bit 3 down.
package salu_pkg;
    typedef enum logic [2:0] {
        OPC_ADD = 3'd0,
        OPC_SUB = 3'd1,
        OPC_AND = 3'd2,
        OPC_OR  = 3'd3,
        OPC_XOR = 3'd4
    } salu_op_e;

    localparam int FLAG_W = 4;
    localparam int FB_C   = 3;
    localparam int FB_V   = 2;
    localparam int FB_N   = 1;
    localparam int FB_Z   = 0;

    localparam logic [FLAG_W-1:0] MASK_ARITH = 4'b1111;
    localparam logic [FLAG_W-1:0] MASK_LOGIC = 4'b0011;
    localparam logic [FLAG_W-1:0] MASK_NONE  = 4'b0000;
endpackage

// File: rtl/salu_shift.sv
// Operand steering shifter: shifts exactly one operand left by sh.
// Assumes sh is below W; the selected operand gets zeros shifted in.
module salu_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic [SW-1:0] sh,
    input  logic          sel_a,
    output logic [W-1:0]  a_out,
    output logic [W-1:0]  b_out
);
    logic [W-1:0] shifted;

    // Pick the operand to shift and apply the left shift.
    always_comb begin
        shifted = (sel_a ? a_in : b_in) << sh;
        a_out   = sel_a ? shifted : a_in;
        b_out   = sel_a ? b_in : shifted;
    end

    // Zero shift must leave both operands untouched.
    always_comb begin
        if (sh == '0) begin
            assert_pass_R3: assert (a_out == a_in && b_out == b_in);
        end
    end
endmodule

// File: rtl/salu_core.sv
// Combinational ALU core: result, candidate flag values and write mask.
// Assumes operands are already shifted; unknown opcodes produce zero and no mask.
module salu_core
    import salu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]        op,
    input  logic [W-1:0]      x,
    input  logic [W-1:0]      y,
    output logic [W-1:0]      res,
    output logic [FLAG_W-1:0] fval,
    output logic [FLAG_W-1:0] fmask
);
    logic [W:0] sum_ext;
    logic [W:0] dif_ext;
    logic       sum_ovf;
    logic       dif_ovf;

    // Wide add and subtract; bit W is carry out or borrow.
    always_comb begin
        sum_ext = {1'b0, x} + {1'b0, y};
        dif_ext = {1'b0, x} - {1'b0, y};
        sum_ovf = (x[W-1] == y[W-1]) && (sum_ext[W-1] != x[W-1]);
        dif_ovf = (x[W-1] != y[W-1]) && (dif_ext[W-1] != x[W-1]);
    end

    // Select the result, flag values and mask for the operation class.
    always_comb begin
        res   = '0;
        fval  = '0;
        fmask = MASK_NONE;
        case (op)
            OPC_ADD: begin
                res        = sum_ext[W-1:0];
                fval[FB_C] = sum_ext[W];
                fval[FB_V] = sum_ovf;
                fmask      = MASK_ARITH;
            end
            OPC_SUB: begin
                res        = dif_ext[W-1:0];
                fval[FB_C] = dif_ext[W];
                fval[FB_V] = dif_ovf;
                fmask      = MASK_ARITH;
            end
            OPC_AND: begin
                res   = x & y;
                fmask = MASK_LOGIC;
            end
            OPC_OR: begin
                res   = x | y;
                fmask = MASK_LOGIC;
            end
            OPC_XOR: begin
                res   = x ^ y;
                fmask = MASK_LOGIC;
            end
            default: begin
                res   = '0;
                fmask = MASK_NONE;
            end
        endcase
        fval[FB_N] = res[W-1];
        fval[FB_Z] = (res == '0);
    end
endmodule

// File: rtl/salu_flags.sv
// Architectural flags register with masked ALU update and direct store.
// Assumes a store on the same edge as an ALU update takes precedence.
module salu_flags
    import salu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [FLAG_W-1:0] upd_mask,
    input  logic [FLAG_W-1:0] upd_val,
    input  logic              st_en,
    input  logic [W-1:0]      st_data,
    output logic [FLAG_W-1:0] flags_q
);
    // Hold flags; store beats the masked merge from the ALU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (st_en) begin
            flags_q <= st_data[FLAG_W-1:0];
        end else if (upd_en) begin
            flags_q <= (flags_q & ~upd_mask) | (upd_val & upd_mask);
        end
    end

    assert_store_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> flags_q == $past(st_data[FLAG_W-1:0]));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !st_en) |=> $stable(flags_q));

    assert_logic_cv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !st_en && !upd_mask[FB_C] && !upd_mask[FB_V])
        |=> flags_q[FB_C:FB_V] == $past(flags_q[FB_C:FB_V]));
endmodule

// File: rtl/shift_alu_flags.sv
// Top: two-stage shifted-operand ALU with the flags register.
// Stage 1 registers the steered shift; stage 2 computes and commits.
// Assumes the caller issues at most one start per cycle.
module shift_alu_flags
    import salu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [SW-1:0] shamt,
    input  logic          shift_a,
    input  logic          keep_flags,
    input  logic          flg_store,
    input  logic [W-1:0]  flg_src,
    output logic          done,
    output logic [W-1:0]  result,
    output logic [W-1:0]  flg_out
);
    logic [W-1:0]      sa, sb;
    logic              s1_vld;
    logic [2:0]        s1_op;
    logic [W-1:0]      s1_x, s1_y;
    logic              s1_keep;
    logic [W-1:0]      c_res;
    logic [FLAG_W-1:0] c_fval, c_fmask;
    logic [FLAG_W-1:0] flags_q;

    salu_shift #(.W(W), .SW(SW)) u_shift (
        .a_in (opnd_a),
        .b_in (opnd_b),
        .sh   (shamt),
        .sel_a(shift_a),
        .a_out(sa),
        .b_out(sb)
    );

    // Stage 1: capture shifted operands and control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_op   <= '0;
            s1_x    <= '0;
            s1_y    <= '0;
            s1_keep <= 1'b0;
        end else begin
            s1_vld <= start;
            if (start) begin
                s1_op   <= op;
                s1_x    <= sa;
                s1_y    <= sb;
                s1_keep <= keep_flags;
            end
        end
    end

    salu_core #(.W(W)) u_core (
        .op   (s1_op),
        .x    (s1_x),
        .y    (s1_y),
        .res  (c_res),
        .fval (c_fval),
        .fmask(c_fmask)
    );

    // Stage 2: register the result and raise the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= s1_vld;
            if (s1_vld) begin
                result <= c_res;
            end
        end
    end

    salu_flags #(.W(W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (s1_vld && !s1_keep),
        .upd_mask(c_fmask),
        .upd_val (c_fval),
        .st_en   (flg_store),
        .st_data (flg_src),
        .flags_q (flags_q)
    );

    // Zero-extend the flags for transfer out.
    always_comb begin
        flg_out             = '0;
        flg_out[FLAG_W-1:0] = flags_q;
    end

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 2));

    assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_keep && !flg_store) |=> $stable(flg_out));
endmodule

// File: tb/shift_alu_flags_test.sv
module shift_alu_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic        shift_a = 1'b0, keep_flags = 1'b0;
    logic        flg_store = 1'b0;
    logic [31:0] flg_src = '0;
    logic        done;
    logic [31:0] result, flg_out;

    shift_alu_flags uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
        .shift_a(shift_a), .keep_flags(keep_flags),
        .flg_store(flg_store), .flg_src(flg_src),
        .done(done), .result(result), .flg_out(flg_out)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic        pol;
        logic        keep;
        logic [31:0] cyc;
    } item_t;

    item_t       sb_q[$];
    int          n_chk = 0, n_fail = 0;
    logic [31:0] cyc = 0;
    logic        mon_on = 1'b0;
    logic        st_prev = 1'b0;
    logic [3:0]  st_val = '0;
    logic [3:0]  mflags = '0;
    bit          finished = 0;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        st_prev <= rst_n && flg_store;
        st_val  <= flg_src[3:0];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference from the requirements: returns {flags, result}.
    function automatic logic [35:0] ref_op(item_t it, logic [3:0] fin);
        logic [31:0] x, y, r;
        logic [32:0] w;
        logic [3:0]  f;
        x = it.pol ? (it.a << it.sh) : it.a;
        y = it.pol ? it.b : (it.b << it.sh);
        f = fin;
        r = 32'h0;
        case (it.op)
            3'd0: begin
                w = {1'b0, x} + {1'b0, y}; r = w[31:0];
                f[3] = w[32];
                f[2] = (x[31] == y[31]) && (r[31] != x[31]);
            end
            3'd1: begin
                r = x - y;
                f[3] = (x < y);
                f[2] = (x[31] != y[31]) && (r[31] != x[31]);
            end
            3'd2: r = x & y;
            3'd3: r = x | y;
            3'd4: r = x ^ y;
            default: r = 32'h0;
        endcase
        if (it.op <= 3'd4) begin
            f[1] = r[31];
            f[0] = (r == 32'h0);
        end
        if (it.keep) f = fin;
        return {f, r};
    endfunction

    // Monitor: pop expected items on done and track flags.
    always @(negedge clk) begin
        if (mon_on && !finished) begin
            logic [3:0]  nf;
            logic [35:0] e;
            item_t       it;
            nf = mflags;
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8 done without start", 32'h1, 32'h0);
                end else begin
                    it = sb_q.pop_front();
                    e  = ref_op(it, mflags);
                    check(result === e[31:0],
                          (it.op == 3'd0) ? "R4 add result" :
                          (it.op == 3'd1) ? "R5 sub result" :
                          (it.op <= 3'd4) ? "R6 logic result" : "R12 undefined result",
                          result, e[31:0]);
                    check(cyc == it.cyc + 2, "R8 latency", cyc, it.cyc + 2);
                    nf = e[35:32];
                end
            end
            if (st_prev) nf = st_val;
            mflags = nf;
            if (done || st_prev)
                check(flg_out === {28'h0, mflags}, "R10 flags", flg_out, {28'h0, mflags});
        end
    end

    task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] s, input logic p, input logic k);
        item_t it;
        @(negedge clk);
        start = 1'b1; op = o; opnd_a = a; opnd_b = b; shamt = s; shift_a = p; keep_flags = k;
        flg_store = 1'b0;
        it = '{op: o, a: a, b: b, sh: s, pol: p, keep: k, cyc: cyc};
        sb_q.push_back(it);
    endtask

    task automatic store(input logic [31:0] v);
        @(negedge clk);
        start = 1'b0; flg_store = 1'b1; flg_src = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0; flg_store = 1'b0;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        check(done === 1'b0, "R13 done", {31'h0, done}, 32'h0);
        check(result === 32'h0, "R13 result", result, 32'h0);
        check(flg_out === 32'h0, "R13 flags", flg_out, 32'h0);
        mon_on = 1'b1;

        issue(3'd0, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b0, 1'b0);  // R4 carry+zero, R3 no shift
        issue(3'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b1, 1'b0);  // R4 overflow, back-to-back R8
        issue(3'd1, 32'h1, 32'h2, 5'd0, 1'b0, 1'b0);          // R5 borrow
        issue(3'd1, 32'h8000_0000, 32'h1, 5'd0, 1'b0, 1'b0);  // R5 overflow
        issue(3'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5'd0, 1'b0, 1'b0); // R6 zero, C/V kept
        issue(3'd0, 32'h1, 32'h1, 5'd4, 1'b1, 1'b0);          // R1 shift A -> 0x11
        issue(3'd1, 32'h100, 32'h1, 5'd4, 1'b0, 1'b0);        // R2 shift B -> 0xF0
        issue(3'd3, 32'h1, 32'h1, 5'd31, 1'b1, 1'b0);         // R1 max shift, R6 negative
        issue(3'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 5'd0, 1'b0, 1'b0); // R6 xor zero
        idle(3);
        store(32'hFFFF_FFF5);                                 // R9 store low nibble, R10 zero-extend
        idle(2);
        issue(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b0, 1'b1); // R7 suppressed
        issue(3'd4, 32'h8000_0000, 32'h0, 5'd0, 1'b0, 1'b0);  // R6 keeps stored C/V
        idle(3);
        issue(3'd5, 32'h1234, 32'h5678, 5'd2, 1'b0, 1'b0);    // R12 undefined op
        issue(3'd7, 32'hFFFF_FFFF, 32'h1, 5'd0, 1'b1, 1'b0);  // R12 undefined op
        idle(3);
        issue(3'd1, 32'h0, 32'h1, 5'd0, 1'b0, 1'b0);          // R11 ALU write meets store
        store(32'h0000_0006);
        idle(3);
        issue(3'd0, 32'h5, 32'h5, 5'd1, 1'b0, 1'b1);          // R11 store with suppressed op
        store(32'h0000_000C);
        idle(4);
        check(sb_q.size() == 0, "R8 all results returned", sb_q.size(), 32'h0);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(1'b0, "R8 watchdog expired", 32'h0, 32'h1);
            summary();
            $finish;
        end
    end
endmodule